// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the write-side controller of a parallel NOR flash model that follows the classic unlock-cycle command protocol. Every bus write arrives as a byte offset and a data word. The block scales the offset to a device word index and checks the pair against the expected unlock, command and argument cycles. It then either programs the word, erases storage, or moves the read side into a different mode.

The backing store is a small byte array inside the block. Programming can only clear bits. An erase fills a whole sector, or the whole array, with 0xFF in one cycle and then waits for an external busy timer. A separate read-data block follows the `rd_mode` output. A bypass mode lets a host skip the two unlock cycles on repeated programs. A query mode, entered by a single write, serves the device's parameter table through the read side.

Top module: `flash_cmd_seq`

## Requirements
- R1: After `rst` is high at a clock edge, `rd_mode` is 0, `in_bypass` is 0, `status` is 0x00 and `erase_start` is 0. Any sequence that was under way is abandoned. Array contents are not changed by reset.
- R2: The word index is the byte offset divided by the device width in bytes (by 2 for the default 2-byte device, so the low offset bit is ignored). All address matching uses this index.
- R3: An unlock pair is data 0xAA at word `UNLOCK0` followed by data 0x55 at word `UNLOCK1`. A write that does not match the expected cycle returns the block to read mode.
- R4: The write after an unlock pair must target word `UNLOCK0`. Data 0x90 selects ID mode (`rd_mode`=1). Data 0xA0 selects program and shows status (`rd_mode`=2). Data 0x80 selects erase setup (`rd_mode`=0). Data 0x20 enters bypass. Any other value returns to read mode (`rd_mode`=0).
- R5: Data 0x98 at word 0x55 enters query mode (`rd_mode`=3). This works from read mode and from ID mode. The next write of any kind returns to read mode.
- R6: Data 0xF0 returns the block to read mode and clears bypass from every state except the program-data cycle. In the program-data cycle it is treated as data.
- R7: The program-data write ANDs each data byte into the stored byte. `status` then becomes {~d7, 7'h7F}, where d7 is bit 7 of the bus data. Outside bypass the block returns to read mode.
- R8: With `big_end`=0, lane i (bits 8i+7:8i) goes to byte (aligned offset + i). With `big_end`=1, the lane order is reversed.
- R9: Erase needs 0x80, then a second unlock pair, then either 0x10 at word `UNLOCK0` (whole array) or 0x30 at any address (the sector holding that offset). The affected bytes become 0xFF and `status` becomes 0x00. `erase_start` pulses for one cycle in the cycle after the write, with `erase_chip` showing which kind of erase it is. A missing unlock pair, or 0x10 at any other word, returns to read mode with no erase.
- R10: While an erase is busy, `rd_mode` is 2 and writes other than 0xF0 are ignored. An `erase_done` pulse inverts `status` bit 7 and returns to read mode, or to the command phase when in bypass.
- R11: In bypass, command writes skip the unlock pair and may target any address. After a program or a finished erase, the block is back in the command phase with bypass still set.
- R12: In bypass, after 0x90 selects ID mode, a write of data 0x00 leaves bypass and returns to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | BUS_AW | Byte offset of the write |
| wr_data | input | 8*DEV_BYTES | Write data; bits 7:0 carry the command byte |
| big_end | input | 1 | Byte-lane order for program data (1 = big-endian) |
| erase_done | input | 1 | Busy timer reports the erase finished |
| rd_mode | output | 2 | Read-side mode: 0 array, 1 ID, 2 status, 3 query |
| status | output | 8 | Status register |
| in_bypass | output | 1 | Bypass mode is active |
| erase_start | output | 1 | One-cycle pulse that starts the busy timer |
| erase_chip | output | 1 | With erase_start: 1 for a whole-array erase |
| peek_addr | input | log2(SECT_BYTES*NUM_SECT) | Byte address of the array read port |
| peek_data | output | 8 | Array byte at peek_addr |

## Verification
The hardest states to reach are the ones behind bypass. Exiting bypass through the ID state, and returning to the command phase after a bypass erase, each need a full unlock, bypass entry, an erase setup with a second unlock pair, and a busy period that the bench ends itself by pulsing `erase_done`. The bench drives those chains in order and confirms the command-phase return by issuing an unlocked 0xA0 at an arbitrary address. It also sweeps all 256 command bytes after an unlock pair and checks the whole array against a bench model after each program and erase pass.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL2, ST_CMD, ST_PROG, ST_ID,
    ST_EU1, ST_EU2, ST_ESEL, ST_BUSY, ST_CFI
  } seq_state_e;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  localparam logic [7:0] C_KEY_A   = 8'hAA;
  localparam logic [7:0] C_KEY_B   = 8'h55;
  localparam logic [7:0] C_ERASE   = 8'h80;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_BYPASS  = 8'h20;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_ABORT   = 8'hF0;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_SECTOR  = 8'h30;
  localparam logic [7:0] C_BYP_OFF = 8'h00;
  localparam int         QUERY_WORD = 'h55;

  // byte offset -> device word index
  function automatic logic [31:0] word_index(logic [31:0] off, int nbytes);
    if (nbytes == 4) return off >> 2;
    if (nbytes == 2) return off >> 1;
    return off;
  endfunction

  // data byte that lands on lane 'lane' of an nbytes-wide word
  function automatic logic [7:0] lane_pick(logic [31:0] data, int lane,
                                           int nbytes, logic big);
    int sel;
    sel = big ? (nbytes - 1 - lane) : lane;
    return data[8*sel +: 8];
  endfunction

  function automatic logic [7:0] status_after_prog(logic d7);
    return {~d7, 7'h7F};
  endfunction

endpackage

// File: rtl/flash_byte_array.sv
module flash_byte_array
  import flash_seq_pkg::*;
#(
  parameter int DEV_BYTES  = 2,
  parameter int SECT_BYTES = 16,
  parameter int NUM_SECT   = 4
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      prog_go,
  input  logic                                      erase_go,
  input  logic                                      erase_all,
  input  logic                                      big_end,
  input  logic [$clog2(SECT_BYTES*NUM_SECT)-1:0]    addr,
  input  logic [8*DEV_BYTES-1:0]                    data,
  input  logic [$clog2(SECT_BYTES*NUM_SECT)-1:0]    peek_addr,
  output logic [7:0]                                peek_data
);
  localparam int MEM_BYTES = SECT_BYTES * NUM_SECT;
  localparam int MEM_AW    = $clog2(MEM_BYTES);
  localparam int SECT_AW   = $clog2(SECT_BYTES);
  localparam logic [MEM_AW-1:0] ALIGN_MASK = ~(MEM_AW'(DEV_BYTES - 1));

  logic [7:0]        mem [MEM_BYTES];
  logic [7:0]        lane_byte [DEV_BYTES];
  logic [MEM_AW-1:0] lane_idx  [DEV_BYTES];
  logic [DEV_BYTES-1:0] lane_we;
  logic [MEM_AW-1:0] word_base;
  logic [MEM_AW-SECT_AW-1:0] sect_sel;
  logic [MEM_AW-1:0] sect_base;

  assign word_base = addr & ALIGN_MASK;
  assign sect_sel  = addr[MEM_AW-1:SECT_AW];
  assign sect_base = MEM_AW'(sect_sel) << SECT_AW;

  for (genvar i = 0; i < DEV_BYTES; i++) begin : g_lane
    assign lane_byte[i] = lane_pick(32'(data), i, DEV_BYTES, big_end);
    assign lane_we[i]   = prog_go;
    assign lane_idx[i]  = word_base + MEM_AW'(i);

    // programming never sets a bit that was clear
    p_clear_only_r7: assert property (@(posedge clk) disable iff (rst)
      lane_we[i] && !erase_go |=>
        (mem[$past(lane_idx[i])] & ~$past(mem[lane_idx[i]])) == 8'h00);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < MEM_BYTES; k++) begin
      if (erase_go && (erase_all || (k >> SECT_AW) == int'(sect_sel)))
        mem[k] <= 8'hFF;
      else if (lane_we[k % DEV_BYTES] && (MEM_AW'(k) & ALIGN_MASK) == word_base)
        mem[k] <= mem[k] & lane_byte[k % DEV_BYTES];
    end
  end

  assign peek_data = mem[peek_addr];

  p_sector_fill_r9: assert property (@(posedge clk) disable iff (rst)
    erase_go |=> mem[$past(sect_base)] == 8'hFF);

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
#(
  parameter int DEV_BYTES = 2,
  parameter int BUS_AW    = 12,
  parameter int UNLOCK0   = 'h555,
  parameter int UNLOCK1   = 'h2AA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [7:0]        cmd,
  input  logic              erase_done,
  output logic              prog_go,
  output logic              erase_go,
  output logic              erase_all,
  output logic [1:0]        rd_mode,
  output logic [7:0]        status,
  output logic              in_bypass,
  output logic              erase_start,
  output logic              erase_chip
);
  seq_state_e state, nxt;
  logic nbyp;
  logic [BUS_AW-1:0] widx;
  logic hit0, hit1, hitq;
  logic ev_abort, ev_done;

  assign widx = BUS_AW'(word_index(32'(wr_addr), DEV_BYTES));
  assign hit0 = (widx == BUS_AW'(UNLOCK0));
  assign hit1 = (widx == BUS_AW'(UNLOCK1));
  assign hitq = (widx == BUS_AW'(QUERY_WORD));
  assign ev_abort = wr_en && (cmd == C_ABORT) && (state != ST_PROG);
  assign ev_done  = (state == ST_BUSY) && erase_done && !ev_abort;

  always_comb begin
    nxt = state; nbyp = in_bypass;
    prog_go = 1'b0; erase_go = 1'b0; erase_all = 1'b0;
    if (state == ST_BUSY) begin
      if (erase_done) nxt = in_bypass ? ST_CMD : ST_READ;
    end else if (wr_en) begin
      nxt = ST_READ; nbyp = 1'b0;       // default on mismatch
      unique case (state)
        ST_READ, ST_EU1: begin
          if (hitq && cmd == C_QUERY) begin nxt = ST_CFI; nbyp = in_bypass; end
          else if (hit0 && cmd == C_KEY_A) begin
            nxt = (state == ST_READ) ? ST_UNL2 : ST_EU2; nbyp = in_bypass;
          end
        end
        ST_UNL2: if (hit1 && cmd == C_KEY_B) begin nxt = ST_CMD; nbyp = in_bypass; end
        ST_EU2:  if (hit1 && cmd == C_KEY_B) begin nxt = ST_ESEL; nbyp = in_bypass; end
        ST_CMD: if (in_bypass || hit0) begin
          nbyp = in_bypass;
          unique case (cmd)
            C_BYPASS: begin nxt = ST_CMD; nbyp = 1'b1; end
            C_ERASE:  nxt = ST_EU1;
            C_IDENT:  nxt = ST_ID;
            C_PROG:   nxt = ST_PROG;
            default:  begin nxt = ST_READ; nbyp = 1'b0; end
          endcase
        end
        ST_PROG: begin
          prog_go = 1'b1; nbyp = in_bypass;
          nxt = in_bypass ? ST_CMD : ST_READ;
        end
        ST_ID: if (!(in_bypass && cmd == C_BYP_OFF) && hitq && cmd == C_QUERY) begin
          nxt = ST_CFI; nbyp = in_bypass;
        end
        ST_ESEL: begin
          if ((cmd == C_CHIP && hit0) || cmd == C_SECTOR) begin
            erase_go = 1'b1; erase_all = (cmd == C_CHIP);
            nxt = ST_BUSY; nbyp = in_bypass;
          end
        end
        default: ;
      endcase
    end
    if (ev_abort) begin
      nxt = ST_READ; nbyp = 1'b0; erase_go = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_READ; in_bypass <= 1'b0; status <= 8'h00;
      erase_start <= 1'b0; erase_chip <= 1'b0;
    end else begin
      state <= nxt; in_bypass <= nbyp;
      erase_start <= erase_go;
      erase_chip  <= erase_go && erase_all;
      if (prog_go)       status <= status_after_prog(cmd[7]);
      else if (erase_go) status <= 8'h00;
      else if (ev_done)  status <= status ^ 8'h80;
    end
  end

  always_comb begin
    unique case (state)
      ST_ID:            rd_mode = RM_IDENT;
      ST_PROG, ST_BUSY: rd_mode = RM_STATUS;
      ST_CFI:           rd_mode = RM_QUERY;
      default:          rd_mode = RM_ARRAY;
    endcase
  end

  p_abort_idle_r6: assert property (@(posedge clk) disable iff (rst)
    ev_abort |=> rd_mode == RM_ARRAY && !in_bypass);
  p_start_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    state == ST_BUSY && !erase_done && !ev_abort |=> rd_mode == RM_STATUS);
  p_done_flip_r10: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> status[7] != $past(status[7]));
  p_query_leave_r5: assert property (@(posedge clk) disable iff (rst)
    state == ST_CFI && wr_en |=> rd_mode == RM_ARRAY);
  p_prog_status_r7: assert property (@(posedge clk) disable iff (rst)
    prog_go |=> status[6:0] == 7'h7F);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int DEV_BYTES  = 2,
  parameter int BUS_AW     = 12,
  parameter int SECT_BYTES = 16,
  parameter int NUM_SECT   = 4,
  parameter int UNLOCK0    = 'h555,
  parameter int UNLOCK1    = 'h2AA
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr_en,
  input  logic [BUS_AW-1:0]                      wr_addr,
  input  logic [8*DEV_BYTES-1:0]                 wr_data,
  input  logic                                   big_end,
  input  logic                                   erase_done,
  output logic [1:0]                             rd_mode,
  output logic [7:0]                             status,
  output logic                                   in_bypass,
  output logic                                   erase_start,
  output logic                                   erase_chip,
  input  logic [$clog2(SECT_BYTES*NUM_SECT)-1:0] peek_addr,
  output logic [7:0]                             peek_data
);
  localparam int MEM_AW = $clog2(SECT_BYTES * NUM_SECT);

  logic prog_go, erase_go, erase_all;

  flash_seq_fsm #(
    .DEV_BYTES(DEV_BYTES), .BUS_AW(BUS_AW),
    .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)
  ) u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .cmd(wr_data[7:0]), .erase_done(erase_done),
    .prog_go(prog_go), .erase_go(erase_go), .erase_all(erase_all),
    .rd_mode(rd_mode), .status(status), .in_bypass(in_bypass),
    .erase_start(erase_start), .erase_chip(erase_chip)
  );

  flash_byte_array #(
    .DEV_BYTES(DEV_BYTES), .SECT_BYTES(SECT_BYTES), .NUM_SECT(NUM_SECT)
  ) u_mem (
    .clk(clk), .rst(rst), .prog_go(prog_go), .erase_go(erase_go),
    .erase_all(erase_all), .big_end(big_end),
    .addr(wr_addr[MEM_AW-1:0]), .data(wr_data),
    .peek_addr(peek_addr), .peek_data(peek_data)
  );

endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;
  localparam logic [11:0] A0B = 12'hAAA;  // word 0x555
  localparam logic [11:0] A1B = 12'h554;  // word 0x2AA
  localparam logic [11:0] QB  = 12'h0AA;  // word 0x55

  logic clk = 0, rst = 1, wr_en = 0, big_end = 0, erase_done = 0;
  logic [11:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  peek_addr = '0;
  logic [1:0]  rd_mode;
  logic [7:0]  status, peek_data;
  logic        in_bypass, erase_start, erase_chip;
  logic [7:0]  model [64];
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  flash_cmd_seq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .big_end(big_end), .erase_done(erase_done), .rd_mode(rd_mode),
    .status(status), .in_bypass(in_bypass), .erase_start(erase_start),
    .erase_chip(erase_chip), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic unl();
    wr(A0B, 16'h00AA); wr(A1B, 16'h0055);
  endtask

  task automatic done_pulse();
    @(negedge clk); erase_done = 1;
    @(negedge clk); erase_done = 0;
  endtask

  task automatic model_prog(logic [11:0] a, logic [15:0] d, logic big);
    int base;
    base = int'(a[5:0]) / 2 * 2;
    for (int i = 0; i < 2; i++) begin
      int sel;
      sel = big ? 1 - i : i;
      model[base + i] = model[base + i] & d[8*sel +: 8];
    end
  endtask

  task automatic prog(logic [11:0] a, logic [15:0] d, logic big);
    big_end = big;
    unl(); wr(A0B, 16'h00A0); wr(a, d);
    model_prog(a, d, big);
  endtask

  task automatic verify_mem(string tag);
    for (int k = 0; k < 64; k++) begin
      peek_addr = 6'(k); #0.1;
      chk(tag, peek_data, model[k]);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", rd_mode, 0);
    chk("R1 bypass", in_bypass, 0);
    chk("R1 status", status, 8'h00);
    chk("R1 erase_start", erase_start, 0);

    // R9 chip erase
    unl(); wr(A0B, 16'h0080); unl(); wr(A0B, 16'h0010);
    chk("R9 start", erase_start, 1);
    chk("R9 chip", erase_chip, 1);
    chk("R9 status clr", status, 8'h00);
    chk("R10 busy mode", rd_mode, 2);
    wr(A0B, 16'h00AA);  // R10 ignored while busy
    chk("R9 start pulse", erase_start, 0);
    chk("R10 busy ignore", rd_mode, 2);
    done_pulse();
    chk("R10 done status", status, 8'h80);
    chk("R10 done mode", rd_mode, 0);
    for (int k = 0; k < 64; k++) model[k] = 8'hFF;
    verify_mem("R9 chip fill");

    // R4 sweep of every command byte
    for (int c = 0; c < 256; c++) begin
      logic [1:0] m;
      m = (c == 'h90) ? 2'd1 : (c == 'hA0) ? 2'd2 : 2'd0;
      unl(); wr(A0B, 16'(c));
      chk("R4 cmd select", {in_bypass, rd_mode}, {(c == 'h20), m});
      if (c == 'hA0) wr(12'h000, 16'hFFFF);
      else wr(12'h000, 16'h00F0);
    end

    // R2 word scaling
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(A0B, 16'h0090);
    chk("R2 unscaled miss", rd_mode, 0);
    wr(12'hAAB, 16'h00AA); wr(12'h555, 16'h0055); wr(A0B, 16'h0090);
    chk("R2 low bit ignored", rd_mode, 1);
    wr(12'h000, 16'h00F0);
    chk("R6 abort from id", rd_mode, 0);

    // R3 unlock mismatches
    wr(A0B, 16'h00AA); wr(A1B, 16'h0054); wr(A0B, 16'h0090);
    chk("R3 bad second data", rd_mode, 0);
    wr(A1B, 16'h00AA); wr(A1B, 16'h0055); wr(A0B, 16'h0090);
    chk("R3 bad first addr", rd_mode, 0);
    unl(); wr(A1B, 16'h0090);
    chk("R4 cmd wrong addr", rd_mode, 0);

    // R5 query entry/exit
    wr(QB, 16'h0098);
    chk("R5 query from idle", rd_mode, 3);
    wr(QB, 16'h0098);
    chk("R5 query exit", rd_mode, 0);
    unl(); wr(A0B, 16'h0090); wr(QB, 16'h0098);
    chk("R5 query from id", rd_mode, 3);
    wr(12'h000, 16'h0000);
    chk("R5 query exit any", rd_mode, 0);
    wr(12'h0AC, 16'h0098);
    chk("R5 wrong word", rd_mode, 0);

    // R7 / R8 programming sweep
    for (int j = 0; j < 16; j++) begin
      logic [15:0] d;
      d = 16'hFFFF ^ (16'h0001 << j) ^ (16'h8000 >> ((j * 5) % 16));
      prog(12'(j * 4), d, j[0]);
      chk("R7 status", status, {~d[7], 7'h7F});
      chk("R7 back to read", rd_mode, 0);
    end
    for (int j = 0; j < 16; j++) begin
      logic [15:0] d;
      d = 16'h5AC3 ^ 16'(j * 16'h1111);
      prog(12'(j * 4 + 1), d, ~j[1]);  // odd offset: aligned down (R8)
      chk("R7 status 2", status, {~d[7], 7'h7F});
    end
    verify_mem("R8 lanes and AND");

    // R6 abort byte is data in the program cycle
    big_end = 0;
    unl(); wr(A0B, 16'h00A0);
    chk("R4 program mode", rd_mode, 2);
    wr(12'h020, 16'h00F0);
    model_prog(12'h020, 16'h00F0, 1'b0);
    chk("R6 data not abort", rd_mode, 0);
    chk("R6 status", status, 8'h7F);
    verify_mem("R6 programmed F0");

    // R9 missing second unlock / wrong chip address
    unl(); wr(A0B, 16'h0080); wr(A0B, 16'h0010);
    chk("R9 no second unlock", {erase_start, rd_mode}, 3'b000);
    unl(); wr(A0B, 16'h0080); unl(); wr(A1B, 16'h0010);
    chk("R9 chip bad addr", {erase_start, rd_mode}, 3'b000);
    verify_mem("R9 nothing erased");

    // R9 sector erase
    for (int s = 1; s < 3; s++) begin
      unl(); wr(A0B, 16'h0080); unl();
      wr(12'h300 | 12'(s * 16 + 6), 16'h0030);
      chk("R9 sector start", {erase_start, erase_chip}, 2'b10);
      chk("R9 sector status", status, 8'h00);
      done_pulse();
      chk("R10 sector done", {status, rd_mode}, {8'h80, 2'd0});
      for (int k = 0; k < 16; k++) model[s * 16 + k] = 8'hFF;
      verify_mem("R9 sector fill");
    end

    // R11 bypass program
    unl(); wr(A0B, 16'h0020);
    chk("R11 bypass on", {in_bypass, rd_mode}, 3'b100);
    wr(12'h3F0, 16'h00A0);
    chk("R11 cmd any addr", rd_mode, 2);
    wr(12'h010, 16'h0F3C);
    model_prog(12'h010, 16'h0F3C, 1'b0);
    chk("R11 back to cmd", {in_bypass, rd_mode}, 3'b100);
    wr(12'h111, 16'h00A0);
    chk("R11 second cmd", rd_mode, 2);
    wr(12'h012, 16'h7E81);
    model_prog(12'h012, 16'h7E81, 1'b0);
    verify_mem("R11 bypass prog");

    // R11/R10 bypass erase returns to command phase
    wr(12'h222, 16'h0080); unl(); wr(12'h030, 16'h0030);
    chk("R11 bypass erase", rd_mode, 2);
    done_pulse();
    for (int k = 48; k < 64; k++) model[k] = 8'hFF;
    chk("R10 bypass done", {in_bypass, rd_mode}, 3'b100);
    wr(12'h444, 16'h00A0);
    chk("R11 cmd after erase", rd_mode, 2);
    wr(12'h034, 16'hFFFF);

    // R12 bypass ID exit
    wr(12'h123, 16'h0090);
    chk("R12 bypass id", {in_bypass, rd_mode}, 3'b101);
    wr(12'h000, 16'h0000);
    chk("R12 bypass exit", {in_bypass, rd_mode}, 3'b000);
    wr(12'h444, 16'h00A0);
    chk("R12 unlock needed again", rd_mode, 0);

    // R1 reset mid-sequence in bypass
    unl(); wr(A0B, 16'h0020); wr(12'h000, 16'h0090);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R1 reset clears", {in_bypass, rd_mode, status}, {1'b0, 2'd0, 8'h00});
    wr(12'h000, 16'h00A0);
    chk("R1 no bypass after", rd_mode, 0);

    // R6 abort during busy
    unl(); wr(A0B, 16'h0080); unl(); wr(12'h005, 16'h0030);
    for (int k = 0; k < 16; k++) model[k] = 8'hFF;
    wr(12'h000, 16'h00F0);
    chk("R6 abort busy", rd_mode, 0);
    verify_mem("R9 final");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule